// File: doc/BRIEF.md
# Shared Smooth Divider Ramp Controller

This block owns the feedback divider settings of two frequency synthesizer channels, a processor-clock channel (CPU) and a reference-clock channel (SRC). Software programs new divider targets through single-cycle register write transactions. The block then moves the live divider value toward the target one count at a time, with a programmable number of clock cycles between counts. The output frequency therefore glides instead of jumping.

There is only one ramp engine, and both channels share it. In automatic mode the engine goes to whichever channel receives a new target while the engine is idle. In manual mode a configuration bit names the owner. A channel that does not hold the engine when its target arrives takes the new value at once, with no ramp.

The CPU channel has a 9-bit N and a 7-bit M. The SRC channel has a 9-bit N, and its M is a fixed parameter. Each channel has an enable bit that chooses between parameter default dividers and the programmed or ramped values.

Top module: `glide_top`

## Requirements
- R1: After reset both enable bits are 0, the mode is automatic and `busy` is 0. Every programmed N and M is 0. The outputs show the defaults `CPU_DEF_N`, `CPU_DEF_M`, `SRC_DEF_N` and `SRC_FIX_M`. Enabling a channel without writing any target shows N = 0, CPU M = 0 and SRC M = `SRC_FIX_M`.
- R2: A channel whose enable bit is 0 outputs its default dividers and keeps its programmed values. Setting the bit again outputs the held programmed values on the next cycle.
- R3: A CPU M value is accepted only when CPU N is written in the same transaction. A transaction that writes M without N leaves M unchanged.
- R4: An accepted CPU M appears on the cycle after the write, with no ramp. The SRC M output is always `SRC_FIX_M`.
- R5: When the owning channel accepts a target that differs from its live N, `busy` rises on the next cycle. The live N then moves by exactly 1 toward the target every `interval` cycles, with the first move `interval` cycles after the write is accepted. `busy` falls on the same cycle that the live N reaches the target.
- R6: A channel that is not the engine owner when its N target arrives shows the new N on the next cycle. This does not disturb a ramp in progress on the other channel.
- R7: In automatic mode an idle engine is granted to the channel written. If one transaction writes N on both channels, the CPU channel ramps and the SRC channel jumps.
- R8: In manual mode the selector picks the owner, 0 for CPU and 1 for SRC. The other channel always jumps.
- R9: The owner does not change while `busy` is high. A selector change made during a ramp takes effect only after the ramp ends.
- R10: A new target for the owner during a ramp replaces the old target. The ramp continues from the current live N, possibly in the other direction, and the interval count restarts at the write.
- R11: The interval register resets to `DEF_INTV`. A written interval of 0 behaves as 1, which gives one step per cycle.
- R12: A target equal to the live N leaves `busy` low and N unchanged.
- R13: Configuration writes (enables, mode, selector, interval) take effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write transaction valid for this cycle |
| wr_cpu_n_we | input | 1 | Transaction carries a CPU N target |
| wr_cpu_n | input | N_W | CPU N target |
| wr_cpu_m_we | input | 1 | Transaction carries a CPU M value |
| wr_cpu_m | input | M_W | CPU M value |
| wr_src_n_we | input | 1 | Transaction carries a SRC N target |
| wr_src_n | input | N_W | SRC N target |
| wr_cfg_we | input | 1 | Transaction writes the configuration bits |
| wr_cpu_en | input | 1 | CPU enable bit value |
| wr_src_en | input | 1 | SRC enable bit value |
| wr_manual | input | 1 | 1 selects manual ownership, 0 automatic |
| wr_sel | input | 1 | Manual owner: 0 CPU, 1 SRC |
| wr_intv_we | input | 1 | Transaction writes the step interval |
| wr_intv | input | INTV_W | Step interval in clock cycles |
| cpu_n | output | N_W | Live CPU N |
| cpu_m | output | M_W | Live CPU M |
| src_n | output | N_W | Live SRC N |
| src_m | output | M_W | Live SRC M |
| busy | output | 1 | Ramp engine active |

## Verification
The bench checks the exact cycle of the first and last step. A counter that is off by one shifts every expected N by a cycle, and a flag cleared one cycle late shows `busy` high next to a finished value. It writes both channels in one transaction, and writes the non-owner while a ramp runs. A design that granted the engine wrongly would ramp the SRC channel, or would stall or reset the CPU ramp. It changes the manual selector during a ramp. A design that switched owner at once would ramp the CPU write instead of jumping it. It also reverses a target mid-ramp, writes M without N, writes a target equal to the live value and uses a zero interval. These catch a restart from the old start point, a stray M update, a spurious `busy` pulse and a counter that wraps.

// File: rtl/glide_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the divider ramp controller.
// Assumes: two channels only; owner encoded in one bit.
package glide_pkg;

    // Which channel currently holds the ramp engine.
    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_SRC = 1'b1
    } owner_e;

    // Configuration bits written together in one transaction.
    typedef struct packed {
        logic   cpu_en;
        logic   src_en;
        logic   manual;
        owner_e sel;
    } cfg_t;

endpackage

// File: rtl/glide_cfg.sv
`timescale 1ns/1ps
// Module: glide_cfg
// Holds the enable, ownership-mode and step-interval registers.
// Assumes: writes qualified by wr_stb; values are visible on the next cycle.
// An interval of zero is presented to the engine as one.
module glide_cfg
    import glide_pkg::*;
#(
    parameter int INTV_W   = 16,
    parameter int DEF_INTV = 133
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              cfg_we,
    input  cfg_t              cfg_in,
    input  logic              intv_we,
    input  logic [INTV_W-1:0] intv_in,
    output cfg_t              cfg,
    output logic [INTV_W-1:0] intv_eff
);
    localparam logic [INTV_W-1:0] INTV_RST = INTV_W'(DEF_INTV);

    cfg_t              cfg_q;
    logic [INTV_W-1:0] intv_q;

    // Purpose: capture configuration bits on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{cpu_en: 1'b0, src_en: 1'b0, manual: 1'b0, sel: OWN_CPU};
        end else if (wr_stb && cfg_we) begin
            cfg_q <= cfg_in;
        end
    end

    // Purpose: capture the step interval on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= INTV_RST;
        end else if (wr_stb && intv_we) begin
            intv_q <= intv_in;
        end
    end

    // Purpose: clamp a zero interval to one cycle.
    always_comb begin
        intv_eff = (intv_q == '0) ? INTV_W'(1) : intv_q;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/glide_chan.sv
`timescale 1ns/1ps
// Module: glide_chan
// One synthesizer channel: live N register (jump or +/-1 step), optional
// programmable M register, and the enable mux toward default dividers.
// Assumes: jump and step never asserted together (engine guarantees it).
module glide_chan #(
    parameter int N_W   = 9,
    parameter int M_W   = 7,
    parameter bit HAS_M = 1'b1,
    parameter int DEF_N = 100,
    parameter int DEF_M = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           jump,
    input  logic [N_W-1:0] jump_val,
    input  logic           m_load,
    input  logic [M_W-1:0] m_val,
    input  logic           step_up,
    input  logic           step_dn,
    output logic [N_W-1:0] cur_n,
    output logic [M_W-1:0] cur_m,
    output logic [N_W-1:0] live_n,
    output logic [M_W-1:0] live_m
);
    localparam logic [N_W-1:0] N_DEFAULT = N_W'(DEF_N);
    localparam logic [M_W-1:0] M_DEFAULT = M_W'(DEF_M);

    logic [N_W-1:0] n_q;

    // Purpose: live N register; jump loads directly, steps move by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '0;
        end else if (jump) begin
            n_q <= jump_val;
        end else if (step_up) begin
            n_q <= n_q + 1'b1;
        end else if (step_dn) begin
            n_q <= n_q - 1'b1;
        end
    end

    generate
        if (HAS_M) begin : g_prog_m
            logic [M_W-1:0] m_q;

            // Purpose: programmable M, loaded without any ramp.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m_q <= '0;
                end else if (m_load) begin
                    m_q <= m_val;
                end
            end

            assign cur_m  = m_q;
            assign live_m = en ? m_q : M_DEFAULT;
        end else begin : g_fixed_m
            logic unused_m_inputs;
            assign unused_m_inputs = m_load ^ (^m_val);
            assign cur_m  = M_DEFAULT;
            assign live_m = M_DEFAULT;
        end
    endgenerate

    assign cur_n  = n_q;
    assign live_n = en ? n_q : N_DEFAULT;

endmodule

// File: rtl/glide_engine.sv
`timescale 1ns/1ps
// Module: glide_engine
// The single shared ramp engine. Decides per transaction which channel
// ramps and which jumps, holds the target of the owner, and issues
// +/-1 step strobes each time the interval counter expires.
// Assumes: intv >= 1; CPU is the first channel of a transaction.
module glide_engine
    import glide_pkg::*;
#(
    parameter int N_W    = 9,
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              manual,
    input  owner_e            sel,
    input  logic [INTV_W-1:0] intv,
    input  logic              req_cpu,
    input  logic              req_src,
    input  logic [N_W-1:0]    val_cpu,
    input  logic [N_W-1:0]    val_src,
    input  logic [N_W-1:0]    cur_cpu,
    input  logic [N_W-1:0]    cur_src,
    output logic              jump_cpu,
    output logic              jump_src,
    output logic              step_cpu_up,
    output logic              step_cpu_dn,
    output logic              step_src_up,
    output logic              step_src_dn,
    output owner_e            owner,
    output logic              busy
);
    owner_e            own_q;
    owner_e            eff_own;
    owner_e            acc_own;
    logic              busy_q;
    logic [N_W-1:0]    tgt_q;
    logic [INTV_W-1:0] cnt_q;
    logic              ramp_cpu;
    logic              ramp_src;
    logic              ramp_any;
    logic [N_W-1:0]    new_tgt;
    logic [N_W-1:0]    req_cur;
    logic [N_W-1:0]    own_cur;
    logic [N_W-1:0]    nxt_cur;
    logic              step_now;
    logic              dir_up;

    // Purpose: pick the channel that may ramp in this transaction.
    always_comb begin
        if (busy_q) begin
            eff_own = own_q;
        end else if (manual) begin
            eff_own = sel;
        end else if (req_cpu) begin
            eff_own = OWN_CPU;
        end else begin
            eff_own = OWN_SRC;
        end
    end

    // Purpose: split each request into ramp (owner) or jump (non-owner).
    always_comb begin
        ramp_cpu = req_cpu && (eff_own == OWN_CPU);
        ramp_src = req_src && (eff_own == OWN_SRC);
        ramp_any = ramp_cpu || ramp_src;
        jump_cpu = req_cpu && !ramp_cpu;
        jump_src = req_src && !ramp_src;
        acc_own  = ramp_cpu ? OWN_CPU : OWN_SRC;
        new_tgt  = ramp_cpu ? val_cpu : val_src;
        req_cur  = ramp_cpu ? cur_cpu : cur_src;
    end

    // Purpose: step timing and direction toward the held target.
    always_comb begin
        own_cur  = (own_q == OWN_SRC) ? cur_src : cur_cpu;
        dir_up   = tgt_q > own_cur;
        step_now = busy_q && !ramp_any && (cnt_q >= intv - 1'b1);
        nxt_cur  = dir_up ? own_cur + 1'b1 : own_cur - 1'b1;
    end

    // Purpose: route the step strobe to the owning channel.
    always_comb begin
        step_cpu_up = step_now && dir_up  && (own_q == OWN_CPU);
        step_cpu_dn = step_now && !dir_up && (own_q == OWN_CPU);
        step_src_up = step_now && dir_up  && (own_q == OWN_SRC);
        step_src_dn = step_now && !dir_up && (own_q == OWN_SRC);
    end

    // Purpose: owner, target, busy flag and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= OWN_CPU;
            busy_q <= 1'b0;
            tgt_q  <= '0;
            cnt_q  <= '0;
        end else if (ramp_any) begin
            own_q  <= acc_own;
            tgt_q  <= new_tgt;
            busy_q <= (new_tgt != req_cur);
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (step_now) begin
                cnt_q <= '0;
                if (nxt_cur == tgt_q) begin
                    busy_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (manual) begin
            own_q <= sel;
        end
    end

    assign owner = own_q;
    assign busy  = busy_q;

endmodule

// File: rtl/glide_top.sv
`timescale 1ns/1ps
// Module: glide_top
// Smooth divider ramp controller for a CPU and a SRC synthesizer channel
// sharing one ramp engine. Register writes arrive as one-cycle transactions.
// Assumes: synchronous active-low reset; the SRC M is a fixed parameter.
module glide_top
    import glide_pkg::*;
#(
    parameter int N_W       = 9,
    parameter int M_W       = 7,
    parameter int INTV_W    = 16,
    parameter int DEF_INTV  = 133,
    parameter int CPU_DEF_N = 100,
    parameter int CPU_DEF_M = 12,
    parameter int SRC_DEF_N = 50,
    parameter int SRC_FIX_M = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_cpu_n_we,
    input  logic [N_W-1:0]    wr_cpu_n,
    input  logic              wr_cpu_m_we,
    input  logic [M_W-1:0]    wr_cpu_m,
    input  logic              wr_src_n_we,
    input  logic [N_W-1:0]    wr_src_n,
    input  logic              wr_cfg_we,
    input  logic              wr_cpu_en,
    input  logic              wr_src_en,
    input  logic              wr_manual,
    input  logic              wr_sel,
    input  logic              wr_intv_we,
    input  logic [INTV_W-1:0] wr_intv,
    output logic [N_W-1:0]    cpu_n,
    output logic [M_W-1:0]    cpu_m,
    output logic [N_W-1:0]    src_n,
    output logic [M_W-1:0]    src_m,
    output logic              busy
);
    cfg_t              cfg_in;
    cfg_t              cfg;
    logic [INTV_W-1:0] intv_eff;
    logic              req_cpu;
    logic              req_src;
    logic              m_load;
    logic              jump_cpu;
    logic              jump_src;
    logic              step_cpu_up;
    logic              step_cpu_dn;
    logic              step_src_up;
    logic              step_src_dn;
    owner_e            owner;
    logic [N_W-1:0]    cpu_cur;
    logic [N_W-1:0]    src_cur;
    logic [M_W-1:0]    cpu_m_raw;
    logic [M_W-1:0]    src_m_raw;

    // Purpose: qualify transaction fields; M only rides along with N.
    always_comb begin
        cfg_in  = '{cpu_en: wr_cpu_en, src_en: wr_src_en, manual: wr_manual,
                    sel: owner_e'(wr_sel)};
        req_cpu = wr_stb && wr_cpu_n_we;
        req_src = wr_stb && wr_src_n_we;
        m_load  = req_cpu && wr_cpu_m_we;
    end

    glide_cfg #(
        .INTV_W   (INTV_W),
        .DEF_INTV (DEF_INTV)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .cfg_we   (wr_cfg_we),
        .cfg_in   (cfg_in),
        .intv_we  (wr_intv_we),
        .intv_in  (wr_intv),
        .cfg      (cfg),
        .intv_eff (intv_eff)
    );

    glide_engine #(
        .N_W    (N_W),
        .INTV_W (INTV_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .manual      (cfg.manual),
        .sel         (cfg.sel),
        .intv        (intv_eff),
        .req_cpu     (req_cpu),
        .req_src     (req_src),
        .val_cpu     (wr_cpu_n),
        .val_src     (wr_src_n),
        .cur_cpu     (cpu_cur),
        .cur_src     (src_cur),
        .jump_cpu    (jump_cpu),
        .jump_src    (jump_src),
        .step_cpu_up (step_cpu_up),
        .step_cpu_dn (step_cpu_dn),
        .step_src_up (step_src_up),
        .step_src_dn (step_src_dn),
        .owner       (owner),
        .busy        (busy)
    );

    glide_chan #(
        .N_W   (N_W),
        .M_W   (M_W),
        .HAS_M (1'b1),
        .DEF_N (CPU_DEF_N),
        .DEF_M (CPU_DEF_M)
    ) u_cpu (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.cpu_en),
        .jump     (jump_cpu),
        .jump_val (wr_cpu_n),
        .m_load   (m_load),
        .m_val    (wr_cpu_m),
        .step_up  (step_cpu_up),
        .step_dn  (step_cpu_dn),
        .cur_n    (cpu_cur),
        .cur_m    (cpu_m_raw),
        .live_n   (cpu_n),
        .live_m   (cpu_m)
    );

    glide_chan #(
        .N_W   (N_W),
        .M_W   (M_W),
        .HAS_M (1'b0),
        .DEF_N (SRC_DEF_N),
        .DEF_M (SRC_FIX_M)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.src_en),
        .jump     (jump_src),
        .jump_val (wr_src_n),
        .m_load   (1'b0),
        .m_val    ('0),
        .step_up  (step_src_up),
        .step_dn  (step_src_dn),
        .cur_n    (src_cur),
        .cur_m    (src_m_raw),
        .live_n   (src_n),
        .live_m   (src_m)
    );

endmodule

// File: rtl/glide_checker.sv
`timescale 1ns/1ps
// Module: glide_checker
// Temporal properties of the ramp controller, bound into glide_top.
module glide_checker #(
    parameter int N_W = 9,
    parameter int M_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           owner,
    input logic [N_W-1:0] cpu_cur,
    input logic [N_W-1:0] src_cur,
    input logic [M_W-1:0] cpu_m_raw,
    input logic           jump_cpu,
    input logic           jump_src,
    input logic           wr_stb,
    input logic           wr_cpu_n_we,
    input logic           wr_cpu_m_we,
    input logic [N_W-1:0] wr_cpu_n,
    input logic [N_W-1:0] wr_src_n
);

    // R5: outside a jump, the CPU live N moves by at most one per cycle
    assert_cpu_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(jump_cpu)) |->
        (cpu_cur == $past(cpu_cur) || cpu_cur == $past(cpu_cur) + 1'b1 ||
         cpu_cur == $past(cpu_cur) - 1'b1));

    // R5: same for the SRC channel
    assert_src_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(jump_src)) |->
        (src_cur == $past(src_cur) || src_cur == $past(src_cur) + 1'b1 ||
         src_cur == $past(src_cur) - 1'b1));

    // R5: an idle engine with no write stays idle
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_stb) |=> !busy);

    // R9: ownership is frozen across consecutive busy cycles
    assert_owner_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(busy) && busy) |-> (owner == $past(owner)));

    // R3: an M write without N leaves M untouched
    assert_m_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_stb && wr_cpu_m_we && !wr_cpu_n_we)) |->
        (cpu_m_raw == $past(cpu_m_raw)));

    // R6: a non-owner CPU write lands in one cycle
    assert_cpu_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(jump_cpu)) |-> (cpu_cur == $past(wr_cpu_n)));

    // R6: a non-owner SRC write lands in one cycle
    assert_src_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(jump_src)) |-> (src_cur == $past(wr_src_n)));

endmodule

bind glide_top glide_checker #(.N_W(N_W), .M_W(M_W)) u_glide_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .owner       (owner),
    .cpu_cur     (cpu_cur),
    .src_cur     (src_cur),
    .cpu_m_raw   (cpu_m_raw),
    .jump_cpu    (jump_cpu),
    .jump_src    (jump_src),
    .wr_stb      (wr_stb),
    .wr_cpu_n_we (wr_cpu_n_we),
    .wr_cpu_m_we (wr_cpu_m_we),
    .wr_cpu_n    (wr_cpu_n),
    .wr_src_n    (wr_src_n)
);

// File: tb/glide_top_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected output snapshots tagged with
// the cycle at which they must hold; a negedge monitor pops and compares.
module glide_top_test;
    localparam int N_W       = 9;
    localparam int M_W       = 7;
    localparam int INTV_W    = 16;
    localparam int CPU_DEF_N = 100;
    localparam int CPU_DEF_M = 12;
    localparam int SRC_DEF_N = 50;
    localparam int SRC_FIX_M = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_stb = 1'b0;
    logic              wr_cpu_n_we = 1'b0;
    logic [N_W-1:0]    wr_cpu_n = '0;
    logic              wr_cpu_m_we = 1'b0;
    logic [M_W-1:0]    wr_cpu_m = '0;
    logic              wr_src_n_we = 1'b0;
    logic [N_W-1:0]    wr_src_n = '0;
    logic              wr_cfg_we = 1'b0;
    logic              wr_cpu_en = 1'b0;
    logic              wr_src_en = 1'b0;
    logic              wr_manual = 1'b0;
    logic              wr_sel = 1'b0;
    logic              wr_intv_we = 1'b0;
    logic [INTV_W-1:0] wr_intv = '0;
    logic [N_W-1:0]    cpu_n;
    logic [M_W-1:0]    cpu_m;
    logic [N_W-1:0]    src_n;
    logic [M_W-1:0]    src_m;
    logic              busy;

    always #2.5 clk = ~clk;

    glide_top #(
        .N_W(N_W), .M_W(M_W), .INTV_W(INTV_W), .DEF_INTV(133),
        .CPU_DEF_N(CPU_DEF_N), .CPU_DEF_M(CPU_DEF_M),
        .SRC_DEF_N(SRC_DEF_N), .SRC_FIX_M(SRC_FIX_M)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .wr_cpu_n_we(wr_cpu_n_we), .wr_cpu_n(wr_cpu_n),
        .wr_cpu_m_we(wr_cpu_m_we), .wr_cpu_m(wr_cpu_m),
        .wr_src_n_we(wr_src_n_we), .wr_src_n(wr_src_n),
        .wr_cfg_we(wr_cfg_we), .wr_cpu_en(wr_cpu_en), .wr_src_en(wr_src_en),
        .wr_manual(wr_manual), .wr_sel(wr_sel),
        .wr_intv_we(wr_intv_we), .wr_intv(wr_intv),
        .cpu_n(cpu_n), .cpu_m(cpu_m), .src_n(src_n), .src_m(src_m), .busy(busy)
    );

    typedef struct {
        int    at;
        int    cn;
        int    cm;
        int    sn;
        int    sm;
        bit    b;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    int m_cpu_n = 0;
    int m_cpu_m = 0;
    int m_src_n = 0;
    bit m_cpu_en = 1'b0;
    bit m_src_en = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Push the model's current visible state as the expectation at cycle 'at'.
    function automatic void expect_at(input int at, input bit b, input string tag);
        exp_t e;
        e.at  = at;
        e.cn  = m_cpu_en ? m_cpu_n : CPU_DEF_N;
        e.cm  = m_cpu_en ? m_cpu_m : CPU_DEF_M;
        e.sn  = m_src_en ? m_src_n : SRC_DEF_N;
        e.sm  = SRC_FIX_M;
        e.b   = b;
        e.tag = tag;
        sbq.push_back(e);
    endfunction

    // Monitor: compare every expectation due in this cycle.
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sbq.size()) begin
            if (sbq[i].at <= cyc) begin
                n_checks++;
                if (sbq[i].at < cyc) begin
                    n_fail++;
                    $display("FAIL %s: expectation for cycle %0d missed at %0d",
                             sbq[i].tag, sbq[i].at, cyc);
                end else if (cpu_n != sbq[i].cn || cpu_m != sbq[i].cm ||
                             src_n != sbq[i].sn || src_m != sbq[i].sm ||
                             busy != sbq[i].b) begin
                    n_fail++;
                    $display("FAIL %s @%0d: actual cpu_n=%0d cpu_m=%0d src_n=%0d src_m=%0d busy=%0b expected cpu_n=%0d cpu_m=%0d src_n=%0d src_m=%0d busy=%0b",
                             sbq[i].tag, cyc, cpu_n, cpu_m, src_n, src_m, busy,
                             sbq[i].cn, sbq[i].cm, sbq[i].sn, sbq[i].sm, sbq[i].b);
                end
                sbq.delete(i);
            end else begin
                i++;
            end
        end
    end

    // Driver: one register transaction, held for one edge.
    task automatic wr(input bit cn_we, input int cn, input bit cm_we, input int cm,
                      input bit sn_we, input int sn);
        wr_stb      = 1'b1;
        wr_cpu_n_we = cn_we;
        wr_cpu_n    = N_W'(cn);
        wr_cpu_m_we = cm_we;
        wr_cpu_m    = M_W'(cm);
        wr_src_n_we = sn_we;
        wr_src_n    = N_W'(sn);
        @(negedge clk);
        wr_stb      = 1'b0;
        wr_cpu_n_we = 1'b0;
        wr_cpu_m_we = 1'b0;
        wr_src_n_we = 1'b0;
    endtask

    task automatic cfg(input bit ce, input bit se, input bit man, input bit sel);
        wr_stb    = 1'b1;
        wr_cfg_we = 1'b1;
        wr_cpu_en = ce;
        wr_src_en = se;
        wr_manual = man;
        wr_sel    = sel;
        @(negedge clk);
        wr_stb    = 1'b0;
        wr_cfg_we = 1'b0;
    endtask

    task automatic set_intv(input int v);
        wr_stb     = 1'b1;
        wr_intv_we = 1'b1;
        wr_intv    = INTV_W'(v);
        @(negedge clk);
        wr_stb     = 1'b0;
        wr_intv_we = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int b;
        repeat (4) @(negedge clk);
        // R1: reset state with channels disabled shows defaults
        expect_at(cyc + 1, 1'b0, "R1 reset defaults");
        expect_at(cyc + 3, 1'b0, "R1 reset defaults held");
        rst_n = 1'b1;
        drain();

        // R11/R13: program a 4-cycle interval, then enable both (R1 R2)
        set_intv(4);
        b = cyc;
        m_cpu_en = 1'b1;
        m_src_en = 1'b1;
        expect_at(b + 1, 1'b0, "R1 R2 R13 enabled shows reset programmed values");
        cfg(1'b1, 1'b1, 1'b0, 1'b0);
        drain();

        // R3 R4 R5 R7: CPU N+M write, idle automatic engine ramps 0 -> 3
        b = cyc;
        m_cpu_m = 5;
        expect_at(b + 1, 1'b1, "R3 R4 M accepted with N, busy rises");
        expect_at(b + 4, 1'b1, "R5 no step before interval");
        m_cpu_n = 1; expect_at(b + 5, 1'b1, "R5 first step");
        m_cpu_n = 2; expect_at(b + 9, 1'b1, "R5 second step");
        m_cpu_n = 3; expect_at(b + 13, 1'b0, "R5 busy falls at target");
        expect_at(b + 14, 1'b0, "R5 held after ramp");
        wr(1'b1, 3, 1'b1, 5, 1'b0, 0);
        drain();

        // R3: M without N is ignored
        b = cyc;
        expect_at(b + 1, 1'b0, "R3 M alone ignored");
        expect_at(b + 3, 1'b0, "R3 M alone still ignored");
        wr(1'b0, 0, 1'b1, 9, 1'b0, 0);
        drain();

        // R7: both channels in one write: CPU ramps down, SRC jumps
        b = cyc;
        m_src_n = 20;
        expect_at(b + 1, 1'b1, "R7 both written: SRC jumps, CPU owns");
        m_cpu_n = 2; expect_at(b + 5, 1'b1, "R5 step down");
        m_cpu_n = 1; expect_at(b + 9, 0, "R7 CPU ramp done");
        wr(1'b1, 1, 1'b0, 0, 1'b1, 20);
        drain();

        // R6: SRC write during CPU ramp jumps, CPU ramp undisturbed
        b = cyc;
        expect_at(b + 1, 1'b1, "R5 CPU ramp start");
        m_src_n = 30; expect_at(b + 2, 1'b1, "R6 SRC jumps while CPU owns");
        m_cpu_n = 2;  expect_at(b + 5, 1'b1, "R6 CPU ramp timing undisturbed");
        m_cpu_n = 3;  expect_at(b + 9, 1'b1, "R6 CPU ramp continues");
        m_cpu_n = 4;  expect_at(b + 13, 1'b1, "R6 CPU ramp continues");
        m_cpu_n = 5;  expect_at(b + 17, 1'b0, "R5 CPU ramp ends");
        wr(1'b1, 5, 1'b0, 0, 1'b0, 0);
        wr(1'b0, 0, 1'b0, 0, 1'b1, 30);
        drain();

        // R10: retarget during a SRC ramp reverses from the live value
        b = cyc;
        expect_at(b + 1, 1'b1, "R7 idle engine granted to SRC");
        m_src_n = 31; expect_at(b + 5, 1'b1, "R10 SRC step up");
        m_src_n = 32; expect_at(b + 9, 1'b1, "R10 SRC step up");
        expect_at(b + 11, 1'b1, "R10 retarget keeps live value");
        expect_at(b + 14, 1'b1, "R10 interval restarts at retarget");
        m_src_n = 31; expect_at(b + 15, 1'b1, "R10 reverse from live value");
        m_src_n = 30; expect_at(b + 19, 1'b0, "R10 reaches new target");
        wr(1'b0, 0, 1'b0, 0, 1'b1, 34);
        repeat (9) @(negedge clk);
        wr(1'b0, 0, 1'b0, 0, 1'b1, 30);
        drain();

        // R8: manual mode, SRC selected; CPU jumps, SRC ramps
        b = cyc;
        m_cpu_n = 7;  expect_at(b + 2, 1'b0, "R8 manual: CPU not owner jumps");
        expect_at(b + 3, 1'b1, "R8 manual: SRC owner ramps");
        m_src_n = 31; expect_at(b + 7, 1'b1, "R8 SRC step");
        m_src_n = 32; expect_at(b + 11, 1'b0, "R8 SRC ramp done");
        cfg(1'b1, 1'b1, 1'b1, 1'b1);
        wr(1'b1, 7, 1'b0, 0, 1'b0, 0);
        wr(1'b0, 0, 1'b0, 0, 1'b1, 32);
        drain();

        // R9: selector moved to CPU during SRC ramp; CPU still jumps until idle
        b = cyc;
        expect_at(b + 1, 1'b1, "R9 SRC ramp start");
        m_cpu_n = 9;  expect_at(b + 3, 1'b1, "R9 CPU jumps while SRC holds engine");
        m_src_n = 33; expect_at(b + 5, 1'b1, "R9 SRC keeps ramping");
        m_src_n = 34; expect_at(b + 9, 1'b1, "R9 SRC keeps ramping");
        m_src_n = 35; expect_at(b + 13, 1'b0, "R9 SRC ramp done");
        expect_at(b + 16, 1'b1, "R8 R9 CPU owns after ramp ends");
        m_cpu_n = 10; expect_at(b + 20, 1'b1, "R8 CPU step");
        m_cpu_n = 11; expect_at(b + 24, 1'b0, "R8 CPU ramp done");
        wr(1'b0, 0, 1'b0, 0, 1'b1, 35);
        cfg(1'b1, 1'b1, 1'b1, 1'b0);
        wr(1'b1, 9, 1'b0, 0, 1'b0, 0);
        repeat (12) @(negedge clk);
        wr(1'b1, 11, 1'b0, 0, 1'b0, 0);
        drain();

        // R2: enable bits switch between defaults and held programmed values
        b = cyc;
        m_cpu_en = 1'b0; expect_at(b + 1, 1'b0, "R2 CPU disabled shows defaults");
        m_cpu_en = 1'b1; expect_at(b + 2, 1'b0, "R2 CPU re-enabled shows held values");
        m_src_en = 1'b0; expect_at(b + 3, 1'b0, "R2 SRC disabled shows defaults");
        m_src_en = 1'b1; expect_at(b + 4, 1'b0, "R2 SRC re-enabled shows held values");
        cfg(1'b0, 1'b1, 1'b1, 1'b0);
        cfg(1'b1, 1'b1, 1'b1, 1'b0);
        cfg(1'b1, 1'b0, 1'b1, 1'b0);
        cfg(1'b1, 1'b1, 1'b1, 1'b0);
        drain();

        // R12: target equal to live N raises no busy; M still loads (R4)
        b = cyc;
        m_cpu_m = 3;
        expect_at(b + 1, 1'b0, "R12 R4 equal target no busy, M loads");
        expect_at(b + 2, 1'b0, "R12 still idle");
        wr(1'b1, 11, 1'b1, 3, 1'b0, 0);
        drain();

        // R11: interval 0 behaves as 1
        b = cyc;
        expect_at(b + 2, 1'b1, "R11 ramp start");
        m_cpu_n = 12; expect_at(b + 3, 1'b1, "R11 zero interval steps every cycle");
        m_cpu_n = 13; expect_at(b + 4, 1'b0, "R11 zero interval ramp done");
        set_intv(0);
        wr(1'b1, 13, 1'b0, 0, 1'b0, 0);
        drain();

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule